// File: doc/BRIEF.md
# Two-Toggle Clock-Crossing Word Link

This block moves data words from a sending node to a neighbouring receiving node when the two run from clocks with no fixed relation to each other. The only handshake between the sides is a pair of toggles. A forward toggle travels with the data bus to the receiver. A return toggle travels back to the sender. A change on either toggle marks one event, whether it rises or falls, so every word costs one flip in each direction.

Each side presents a valid/ready interface to its local logic. The sending side holds the accepted word on the link bus and flips its toggle. The receiving side synchronizes that toggle into its own clock and detects the change. It then latches the word and offers it to its consumer. It flips the return toggle only once the consumer has taken the word. The sender synchronizes the return toggle and accepts its next word once the two toggles agree again. Only one word is ever in flight.

Top module: `toggle_link_top`

## Requirements
- R1: While its reset is held and in the first cycle after it, each side is idle: the sender reports `s_ready` = 1 and its forward toggle is 0, and the receiver reports `m_valid` = 0 and its return toggle is 0.
- R2: A word is accepted on a sending-clock edge where `s_valid` and `s_ready` are both 1. From the next sending cycle, `s_ready` stays 0 until the return toggle, after synchronization, matches the forward toggle again.
- R3: Each accepted word appears on `m_data` with `m_valid` = 1, bit for bit. This holds for a rising forward toggle (odd-numbered words after reset) and for a falling one (even-numbered words).
- R4: While `m_valid` = 1 and `m_ready` = 0, `m_valid` stays 1 and `m_data` stays unchanged. The return toggle changes only in the cycle after a word is taken (`m_valid` and `m_ready` both 1). The sender therefore stays not ready for as long as the consumer stalls.
- R5: Words arrive in the order they were accepted, with none lost and none duplicated, even when both sides stream back to back.
- R6: While a word is in flight, the link data bus holds the accepted value. Changes on `s_data` after acceptance do not affect the word delivered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Sending-side clock |
| rst_a | input | 1 | Synchronous active-high reset, sending side |
| s_valid | input | 1 | Sending-side word offered |
| s_data | input | DATA_W | Sending-side word |
| s_ready | output | 1 | Sender can accept a word this cycle |
| clk_b | input | 1 | Receiving-side clock |
| rst_b | input | 1 | Synchronous active-high reset, receiving side |
| m_valid | output | 1 | A received word is held for the consumer |
| m_ready | input | 1 | Consumer takes the held word |
| m_data | output | DATA_W | Received word |

## Verification
A wrong internal state shows at the ports within a few clock cycles of either side. A sender toggle that flips without an accepted word, or a return toggle that flips early, causes a spurious or duplicated word at `m_valid`. It can also cause `s_ready` to rise while the consumer still stalls, which is seen on the next word or during the stall. A bad capture point or bus hold shows as a wrong `m_data` on the word concerned. Because the bench corrupts `s_data` right after each acceptance, a bus that is not held is caught at once. A toggle polarity bug shows up on the first or second word after reset, depending on which edge is affected.

// File: rtl/toggle_link_pkg.sv
package toggle_link_pkg;
  // Smallest synchronizer depth the link is built for.
  localparam int unsigned SYNC_MIN = 2;

  // Two-phase event: any difference from the last observed level.
  function automatic logic toggle_event(input logic now_lvl, input logic prev_lvl);
    return now_lvl ^ prev_lvl;
  endfunction
endpackage

// File: rtl/tl_sync.sv
module tl_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES < toggle_link_pkg::SYNC_MIN) begin : g_bad
      initial $error("tl_sync: STAGES below minimum");
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/tl_tx.sv
module tl_tx #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s_valid,
  input  logic [DATA_W-1:0] s_data,
  output logic              s_ready,
  input  logic              ack_sync,
  output logic              link_req,
  output logic [DATA_W-1:0] link_data
);
  logic              req_q;
  logic [DATA_W-1:0] hold_q;

  // Idle when both toggles agree: no word in flight.
  assign s_ready = (req_q == ack_sync);

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= 1'b0;
      hold_q <= '0;
    end else if (s_valid && s_ready) begin
      req_q  <= ~req_q;
      hold_q <= s_data;
    end
  end

  assign link_req  = req_q;
  assign link_data = hold_q;
endmodule

// File: rtl/tl_rx.sv
module tl_rx #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_sync,
  input  logic [DATA_W-1:0] link_data,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data,
  output logic              link_ack
);
  import toggle_link_pkg::*;

  logic              seen_q;
  logic              ack_q;
  logic              full_q;
  logic [DATA_W-1:0] word_q;
  logic              evt;

  assign evt = toggle_event(req_sync, seen_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q <= 1'b0;
      ack_q  <= 1'b0;
      full_q <= 1'b0;
      word_q <= '0;
    end else if (full_q && m_ready) begin
      full_q <= 1'b0;
      ack_q  <= ~ack_q;
    end else if (!full_q && evt) begin
      full_q <= 1'b1;
      word_q <= link_data;
      seen_q <= req_sync;
    end
  end

  assign m_valid  = full_q;
  assign m_data   = word_q;
  assign link_ack = ack_q;
endmodule

// File: rtl/toggle_link_top.sv
module toggle_link_top #(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_a,
  input  logic              rst_a,
  input  logic              s_valid,
  input  logic [DATA_W-1:0] s_data,
  output logic              s_ready,
  input  logic              clk_b,
  input  logic              rst_b,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data
);
  logic              link_req;
  logic              link_ack;
  logic [DATA_W-1:0] link_data;
  logic              req_sync_b;
  logic              ack_sync_a;

  tl_tx #(.DATA_W(DATA_W)) u_tx (
    .clk(clk_a), .rst(rst_a),
    .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .ack_sync(ack_sync_a),
    .link_req(link_req), .link_data(link_data)
  );

  tl_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(clk_b), .rst(rst_b), .d(link_req), .q(req_sync_b)
  );

  tl_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(clk_a), .rst(rst_a), .d(link_ack), .q(ack_sync_a)
  );

  tl_rx #(.DATA_W(DATA_W)) u_rx (
    .clk(clk_b), .rst(rst_b),
    .req_sync(req_sync_b), .link_data(link_data),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .link_ack(link_ack)
  );
endmodule

// File: rtl/tl_link_checker.sv
module tl_link_checker #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk_a,
  input logic              rst_a,
  input logic              clk_b,
  input logic              rst_b,
  input logic              s_valid,
  input logic              s_ready,
  input logic              link_req,
  input logic              link_ack,
  input logic              ack_sync_a,
  input logic [DATA_W-1:0] link_data,
  input logic              m_valid,
  input logic              m_ready,
  input logic [DATA_W-1:0] m_data
);
  AST_TX_RESET_IDLE: assert property (@(posedge clk_a)
    rst_a |=> (!link_req && s_ready)); // R1

  AST_RX_RESET_IDLE: assert property (@(posedge clk_b)
    rst_b |=> (!m_valid && !link_ack)); // R1

  AST_ACCEPT_BLOCKS: assert property (@(posedge clk_a) disable iff (rst_a)
    (s_valid && s_ready) |=> !s_ready); // R2

  AST_BUS_HELD: assert property (@(posedge clk_a) disable iff (rst_a)
    (link_req != ack_sync_a) |=> $stable(link_data)); // R6

  AST_RX_HOLD: assert property (@(posedge clk_b) disable iff (rst_b)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data))); // R4

  AST_ACK_ON_TAKE: assert property (@(posedge clk_b) disable iff (rst_b)
    (link_ack != $past(link_ack)) |-> $past(m_valid && m_ready)); // R4
endmodule

bind toggle_link_top tl_link_checker #(.DATA_W(DATA_W)) u_chk (
  .clk_a(clk_a), .rst_a(rst_a), .clk_b(clk_b), .rst_b(rst_b),
  .s_valid(s_valid), .s_ready(s_ready),
  .link_req(link_req), .link_ack(link_ack), .ack_sync_a(ack_sync_a),
  .link_data(link_data),
  .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data)
);

// File: tb/toggle_link_top_test.sv
module toggle_link_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_B_HALF = 7;
  localparam int DW = 16;
  localparam int NVEC = 8;
  localparam int NSTREAM = 16;

  // {stall cycles[3:0], data[15:0]}
  localparam logic [DW+3:0] VEC [NVEC] = '{
    {4'd0, 16'h1234}, {4'd3, 16'hFFFF}, {4'd0, 16'h0000}, {4'd5, 16'hA5A5},
    {4'd1, 16'h5A5A}, {4'd2, 16'h8001}, {4'd0, 16'h7FFE}, {4'd7, 16'hC3C3}
  };

  logic clk_a = 1'b0, clk_b = 1'b0;
  logic rst_a = 1'b1, rst_b = 1'b1;
  logic s_valid = 1'b0, m_ready = 1'b0;
  logic [DW-1:0] s_data = '0;
  logic s_ready, m_valid;
  logic [DW-1:0] m_data;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_a = ~clk_a;
  always #(CLK_B_HALF) clk_b = ~clk_b;

  toggle_link_top #(.DATA_W(DW), .SYNC_STAGES(2)) uut (
    .clk_a(clk_a), .rst_a(rst_a), .s_valid(s_valid), .s_data(s_data),
    .s_ready(s_ready), .clk_b(clk_b), .rst_b(rst_b), .m_valid(m_valid),
    .m_ready(m_ready), .m_data(m_data)
  );

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_word(input logic [DW-1:0] d);
    @(negedge clk_a);
    s_valid = 1'b1;
    s_data  = d;
    while (!s_ready) @(negedge clk_a);
    @(negedge clk_a);  // accepted at the posedge in between
    s_valid = 1'b0;
    s_data  = ~d;      // R6: disturb the source bus after acceptance
    check(s_ready == 1'b0, "R2 not ready after accept", DW'(s_ready), '0);
  endtask

  task automatic recv_word(input logic [DW-1:0] exp, input int stall);
    @(negedge clk_b);
    while (!m_valid) @(negedge clk_b);
    check(m_data == exp, "R3/R6 received word", m_data, exp);
    for (int i = 0; i < stall; i++) begin
      @(negedge clk_b);
      check(m_valid && m_data == exp, "R4 held during stall", m_data, exp);
      check(s_ready == 1'b0, "R4 sender held off", DW'(s_ready), '0);
    end
    m_ready = 1'b1;
    @(negedge clk_b);
    m_ready = 1'b0;
    check(m_valid == 1'b0, "R4 word taken", DW'(m_valid), '0);
  endtask

  task automatic wait_ready;
    int guard = 0;
    @(negedge clk_a);
    while (!s_ready && guard < 50) begin
      @(negedge clk_a);
      guard++;
    end
    check(s_ready == 1'b1, "R2 ready after return toggle", DW'(s_ready), 1);
  endtask

  initial begin
    repeat (4) @(negedge clk_b);
    check(s_ready == 1'b1, "R1 reset s_ready", DW'(s_ready), 1);
    check(m_valid == 1'b0, "R1 reset m_valid", DW'(m_valid), 0);
    @(negedge clk_a); rst_a = 1'b0;
    @(negedge clk_b); rst_b = 1'b0;
    @(negedge clk_a);
    check(s_ready == 1'b1, "R1 after reset s_ready", DW'(s_ready), 1);
    check(m_valid == 1'b0, "R1 after reset m_valid", DW'(m_valid), 0);

    // Vector table: alternating toggle polarity each word (R3).
    for (int v = 0; v < NVEC; v++) begin
      fork
        send_word(VEC[v][DW-1:0]);
        recv_word(VEC[v][DW-1:0], int'(VEC[v][DW+3:DW]));
      join
      wait_ready();
    end

    // Idle link: no spurious word appears (R5).
    repeat (20) @(negedge clk_b);
    check(m_valid == 1'b0, "R5 no spurious word", DW'(m_valid), 0);

    // Back-to-back stream with consumer always ready (R5).
    fork
      begin
        for (int k = 0; k < NSTREAM; k++) send_word(DW'(16'h3000 + k * 7));
      end
      begin
        int got = 0;
        int guard = 0;
        m_ready = 1'b1;
        while (got < NSTREAM && guard < 2000) begin
          @(negedge clk_b);
          guard++;
          if (m_valid) begin
            check(m_data == DW'(16'h3000 + got * 7), "R5 stream order",
                  m_data, DW'(16'h3000 + got * 7));
            got++;
          end
        end
        check(got == NSTREAM, "R5 stream count", DW'(got), DW'(NSTREAM));
        repeat (20) @(negedge clk_b);
        check(m_valid == 1'b0, "R5 no duplicate", DW'(m_valid), 0);
        m_ready = 1'b0;
      end
    join

    // Reset mid-idle returns both sides to idle (R1).
    @(negedge clk_a); rst_a = 1'b1;
    @(negedge clk_b); rst_b = 1'b1;
    repeat (3) @(negedge clk_b);
    check(s_ready == 1'b1 && m_valid == 1'b0, "R1 re-reset idle",
          DW'({s_ready, m_valid}), DW'(2'b10));

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule